// File: doc/BRIEF.md
# Laser Transmit Safety Controller

This block decides, cycle by cycle, whether an optical transmitter's laser may emit. It combines four conditions: a board-level disable pin, a disable bit written by software, a supply-good indication from the supply supervisor, and a raw fault detect from the laser monitoring circuit. Any one of them turns the laser off. A detected fault is latched and reported on a status output. The fault stays latched after the fault condition goes away. Only one action clears it: holding the disable pin high for a minimum time and then releasing it.

After the supply returns, a power-on hold keeps the laser dark for a long fixed interval. An initialisation window then runs before the block reports itself ready. The same window also runs after a fault has been cleared through the disable pin.

All intervals are counted in ticks. A prescaler divides the clock into ticks, so a production build can count microseconds while a simulation build uses a few cycles per tick. The pin inputs pass through synchronisers. The board must pull the disable pin up, so that an undriven pin reads as disabled. The analog laser driver, the power loop and the supply sensing itself lie outside this block.

Top module: `laser_safety_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycles after it, `laser_en_o`, `fault_o` and `ready_o` are all 0.
- R2: A high level on `hw_disable_i` forces `laser_en_o` to 0 within SYNC_STAGES+2 clock cycles. Returning it low re-enables the laser within the same delay when nothing else blocks it.
- R3: `soft_disable_i` high forces `laser_en_o` to 0 from the next clock edge on. It acts independently of `hw_disable_i`, and the laser is enabled only when both are low.
- R4: While `supply_ok_i` is low, `laser_en_o`, `ready_o` and `fault_o` are 0. After it returns high, `laser_en_o` stays 0 for at least POR_TICKS and at most POR_TICKS+1 tick periods, plus synchroniser latency.
- R5: A high level on `fault_raw_i` drives `fault_o` to 1 and `laser_en_o` and `ready_o` to 0 within SYNC_STAGES+2 cycles.
- R6: Once set, `fault_o` stays 1 after `fault_raw_i` returns low. A disable pulse shorter than CLR_TICKS tick periods does not clear it.
- R7: Holding `hw_disable_i` high for more than CLR_TICKS+1 tick periods and then releasing it clears `fault_o`, when the fault condition has gone.
- R8: If `fault_raw_i` is still high when the qualifying disable pulse is released, `fault_o` stays 1.
- R9: `ready_o` rises only after the power-on hold and then an initialisation window of INIT_TICKS to INIT_TICKS+1 tick periods have elapsed with no latched fault. A fault cleared through the disable pin restarts that window.
- R10: `laser_en_o` is a register equal to: supply past its hold, disable pin low, soft disable low, and no fault latched or detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply above reset threshold (asynchronous) |
| hw_disable_i | input | 1 | Disable pin, high or pulled-up means off (asynchronous) |
| soft_disable_i | input | 1 | Software disable bit, synchronous to `clk` |
| fault_raw_i | input | 1 | Raw laser fault detect (asynchronous) |
| laser_en_o | output | 1 | Registered laser enable |
| fault_o | output | 1 | Latched fault status |
| ready_o | output | 1 | Hold and initialisation done, no fault |

## Verification
The hardest state to reach is the clear of a latched fault at the boundary. The disable pin has to be held across a tick-quantised interval, and the fault detect may or may not still be active when the pin is released. The stimulus uses a small tick configuration. It drives a disable pulse shorter than the clear interval and one longer than it, and it releases the long pulse once with the fault still present. The measured delays to laser enable and to ready are then compared against tick-count windows computed in the bench.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  // Asynchronous pins brought into the clock domain together.
  typedef struct packed {
    logic supply_ok;
    logic hw_disable;
    logic fault_raw;
  } lsc_pins_t;

  // Safe values while synchronisers are in reset: supply bad, laser disabled.
  localparam lsc_pins_t PINS_SAFE = '{supply_ok: 1'b0, hw_disable: 1'b1, fault_raw: 1'b0};
endpackage

// File: rtl/lsc_sync.sv
module lsc_sync #(
  parameter int unsigned STAGES = 2,
  parameter lsc_pkg::lsc_pins_t RST_VAL = lsc_pkg::PINS_SAFE
) (
  input  logic               clk,
  input  logic               rst,
  input  lsc_pkg::lsc_pins_t d,
  output lsc_pkg::lsc_pins_t q
);
  lsc_pkg::lsc_pins_t stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= RST_VAL;
        else if (g == 0) stage[g] <= d;
        else stage[g] <= stage[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/lsc_tick_gen.sv
module lsc_tick_gen #(
  parameter int unsigned CYC_PER_TICK = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_TICK - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lsc_tick_timer.sv
module lsc_tick_timer #(
  parameter int unsigned TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] TERM = CW'(TICKS);

  logic [CW-1:0] cnt;

  // Done after TICKS+1 ticks, so at least TICKS full tick periods elapse.
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (run && tick && !done) begin
      if (cnt == TERM) done <= 1'b1;
      else cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/laser_safety_ctrl.sv
module laser_safety_ctrl #(
  parameter int unsigned CYC_PER_TICK = 100,
  parameter int unsigned POR_TICKS    = 140000,
  parameter int unsigned INIT_TICKS   = 300000,
  parameter int unsigned CLR_TICKS    = 10,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic hw_disable_i,
  input  logic soft_disable_i,
  input  logic fault_raw_i,
  output logic laser_en_o,
  output logic fault_o,
  output logic ready_o
);
  import lsc_pkg::*;

  lsc_pins_t pins_raw, pins_s;
  logic      tick;
  logic      hw_dis_d;
  logic      por_done, init_done, clr_armed;
  logic      clear_evt, fault_nxt;

  assign pins_raw = '{supply_ok: supply_ok_i, hw_disable: hw_disable_i, fault_raw: fault_raw_i};

  lsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PINS_SAFE)) sync_i (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  lsc_tick_gen #(.CYC_PER_TICK(CYC_PER_TICK)) tick_i (
    .clk(clk), .rst(rst), .tick(tick)
  );

  // Power-on hold: restarts whenever the supply is bad.
  lsc_tick_timer #(.TICKS(POR_TICKS)) por_tmr_i (
    .clk(clk), .rst(rst), .restart(!pins_s.supply_ok), .run(1'b1),
    .tick(tick), .done(por_done)
  );

  // Initialisation window: runs after the hold, restarts on a fault clear.
  lsc_tick_timer #(.TICKS(INIT_TICKS)) init_tmr_i (
    .clk(clk), .rst(rst), .restart(!pins_s.supply_ok || clear_evt), .run(por_done),
    .tick(tick), .done(init_done)
  );

  // Disable-hold qualifier for clearing a latched fault.
  lsc_tick_timer #(.TICKS(CLR_TICKS)) clr_tmr_i (
    .clk(clk), .rst(rst), .restart(!pins_s.hw_disable), .run(1'b1),
    .tick(tick), .done(clr_armed)
  );

  always_ff @(posedge clk) begin
    if (rst) hw_dis_d <= 1'b1;
    else hw_dis_d <= pins_s.hw_disable;
  end

  // Falling edge of the synchronised disable after a long enough hold.
  assign clear_evt = hw_dis_d && !pins_s.hw_disable && clr_armed;

  // A present fault always wins over a clear.
  always_comb begin
    if (!pins_s.supply_ok) fault_nxt = 1'b0;
    else fault_nxt = pins_s.fault_raw || (fault_o && !clear_evt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_o    <= 1'b0;
      laser_en_o <= 1'b0;
      ready_o    <= 1'b0;
    end else begin
      fault_o    <= fault_nxt;
      laser_en_o <= pins_s.supply_ok && por_done && !pins_s.hw_disable
                    && !soft_disable_i && !fault_nxt;
      ready_o    <= pins_s.supply_ok && por_done && init_done && !fault_nxt;
    end
  end
endmodule

// File: rtl/laser_safety_ctrl_chk.sv
module laser_safety_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic soft_disable_i,
  input logic laser_en_o,
  input logic fault_o,
  input logic ready_o,
  input lsc_pkg::lsc_pins_t pins_s,
  input logic clear_evt
);
  // R5
  fault_keeps_laser_off_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!laser_en_o && !ready_o));

  // R3
  soft_disable_off_chk: assert property (@(posedge clk) disable iff (rst)
    soft_disable_i |=> !laser_en_o);

  // R2
  hw_disable_off_chk: assert property (@(posedge clk) disable iff (rst)
    pins_s.hw_disable |=> !laser_en_o);

  // R4
  supply_low_off_chk: assert property (@(posedge clk) disable iff (rst)
    !pins_s.supply_ok |=> (!laser_en_o && !ready_o && !fault_o));

  // R6
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_o && !clear_evt && pins_s.supply_ok) |=> fault_o);

  // R8
  fault_present_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (pins_s.fault_raw && pins_s.supply_ok) |=> fault_o);
endmodule

bind laser_safety_ctrl laser_safety_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .soft_disable_i(soft_disable_i),
  .laser_en_o(laser_en_o), .fault_o(fault_o), .ready_o(ready_o),
  .pins_s(pins_s), .clear_evt(clear_evt)
);

// File: tb/laser_safety_ctrl_tb_top.sv
`timescale 1ns/1ps
module laser_safety_ctrl_tb_top;
  localparam int CYC  = 4;
  localparam int POR  = 5;
  localparam int INIT = 6;
  localparam int CLR  = 3;
  localparam int SYN  = 2;

  logic clk = 1'b0;
  logic rst, supply_ok, hw_dis, soft_dis, fault_raw;
  logic laser_en, fault, ready;
  int   n_chk = 0;
  int   n_fail = 0;

  always #5 clk = ~clk;

  laser_safety_ctrl #(
    .CYC_PER_TICK(CYC), .POR_TICKS(POR), .INIT_TICKS(INIT),
    .CLR_TICKS(CLR), .SYNC_STAGES(SYN)
  ) dut_i (
    .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .hw_disable_i(hw_dis),
    .soft_disable_i(soft_dis), .fault_raw_i(fault_raw),
    .laser_en_o(laser_en), .fault_o(fault), .ready_o(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count cycles until the selected output is high (0: laser_en, 1: ready).
  task automatic count_until(input int sel, output int n);
    n = 0;
    while (((sel == 0) ? laser_en : ready) !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n, lo, hi;
    rst = 1'b1; supply_ok = 1'b0; hw_dis = 1'b1; soft_dis = 1'b0; fault_raw = 1'b0;
    cyc(3);
    // R1 reset state
    check(laser_en == 0 && fault == 0 && ready == 0, "R1", {laser_en, fault, ready}, 0);
    rst = 1'b0;
    cyc(2);
    check(laser_en == 0 && fault == 0 && ready == 0, "R1", {laser_en, fault, ready}, 0);

    // R4 / R9: power-on hold then init window
    supply_ok = 1'b1; hw_dis = 1'b0;
    count_until(0, n);
    lo = POR * CYC; hi = SYN + (POR + 1) * CYC + 3;
    check(n >= lo && n <= hi, "R4 hold", n, lo);
    begin
      int m;
      count_until(1, m);
      m += n;
      lo = (POR + INIT) * CYC; hi = SYN + (POR + INIT + 2) * CYC + 4;
      check(m >= lo && m <= hi, "R9 init", m, lo);
    end

    // R2 / R3 / R10: sweep disable combinations
    for (int c = 0; c < 4; c++) begin
      hw_dis = c[0]; soft_dis = c[1];
      cyc(SYN + 2);
      check(laser_en == !(c[0] | c[1]), (c[0] ? "R2 sweep R10" : "R3 sweep R10"),
            laser_en, !(c[0] | c[1]));
    end
    hw_dis = 1'b0; soft_dis = 1'b0;
    cyc(SYN + 2);
    check(laser_en == 1, "R2 reenable", laser_en, 1);
    soft_dis = 1'b1; cyc(1);
    check(laser_en == 0, "R3 next edge", laser_en, 0);
    soft_dis = 1'b0; cyc(2);

    // R5: fault latches
    fault_raw = 1'b1; cyc(SYN + 2);
    check(fault == 1 && laser_en == 0 && ready == 0, "R5", {fault, laser_en, ready}, 3'b100);
    fault_raw = 1'b0; cyc(20);
    check(fault == 1, "R6 sticky", fault, 1);
    // R6: short disable pulse does not clear
    hw_dis = 1'b1; cyc(CYC); hw_dis = 1'b0; cyc(SYN + 4);
    check(fault == 1 && laser_en == 0, "R6 short pulse", fault, 1);
    // R7: long pulse clears
    hw_dis = 1'b1; cyc((CLR + 2) * CYC);
    check(laser_en == 0, "R2 during hold", laser_en, 0);
    hw_dis = 1'b0; cyc(SYN + 3);
    check(fault == 0 && laser_en == 1, "R7 clear", {fault, laser_en}, 2'b01);
    // R9: init window restarts after clear
    count_until(1, n);
    n += SYN + 3;
    lo = INIT * CYC; hi = SYN + (INIT + 1) * CYC + 6;
    check(n >= lo && n <= hi, "R9 after clear", n, lo);

    // R8: fault still present at release
    fault_raw = 1'b1; cyc(SYN + 2);
    hw_dis = 1'b1; cyc((CLR + 2) * CYC); hw_dis = 1'b0; cyc(SYN + 4);
    check(fault == 1, "R8 present at release", fault, 1);
    fault_raw = 1'b0; cyc(10);
    check(fault == 1, "R8 still latched", fault, 1);
    hw_dis = 1'b1; cyc((CLR + 2) * CYC); hw_dis = 1'b0; cyc(SYN + 3);
    check(fault == 0, "R7 clear again", fault, 0);

    // R4: supply loss clears everything, hold restarts
    fault_raw = 1'b1; cyc(SYN + 2); fault_raw = 1'b0;
    supply_ok = 1'b0; cyc(SYN + 2);
    check(fault == 0 && laser_en == 0 && ready == 0, "R4 supply low", {fault, laser_en, ready}, 0);
    supply_ok = 1'b1;
    count_until(0, n);
    lo = POR * CYC; hi = SYN + (POR + 1) * CYC + 3;
    check(n >= lo && n <= hi, "R4 hold again", n, lo);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule